// File: doc/BRIEF.md
# Pipeline Exception Commit Controller

This block holds the exception control state for a five-stage in-order pipeline: fetch, decode, execute, memory and writeback. A fault raised by fetch, decode or execute is not acted on when it appears. It is attached to the instruction as a flag and a cause code, and it moves with that instruction until the instruction reaches the memory stage. The memory stage is the single commit point. There the block chooses between an external interrupt, an exception the instruction already carries, and a data-address fault raised in that stage.

When an exception is taken, the controller does four things in the same cycle. It kills the fetch, decode and execute stages. It blocks writeback of the instruction at the commit point. It asserts a redirect with the handler address. At the next clock edge it loads the cause register, and it loads the exception-PC register with the PC of the committing instruction. The interrupt request may come from another clock domain. It is synchronized, its rising edge is detected, and the request stays pending until a valid instruction reaches commit and can take it.

The surrounding pipeline advances one stage per clock. It gives the fetch PC and a valid bit, and it gives one fault strobe per stage for the instruction in that stage. The controller carries the PCs down the pipeline itself, in step with the flags.

Top module: `exc_commit_ctrl`

## Requirements
- R1: A fault is acted on only at commit. An instruction that enters decode at clock edge n reaches commit after edge n+2, and redirect is first asserted in the cycle that follows edge n+2. Until then it causes no redirect.
- R2: Within one instruction, the cause from the earliest stage that raised a fault is kept. Faults raised in later stages do not change it.
- R3: When the interrupt is pending and commit holds a valid instruction, the exception taken has cause 5, even if that instruction also carries a fault or raises one. The exception PC is the PC of that instruction.
- R4: After reset, the cause register is 0 and the exception PC is 0. The two registers are loaded at the clock edge that ends a redirect cycle, and they hold their values at every other edge.
- R5: While redirect is asserted, kill_fetch_o, kill_dec_o, kill_exe_o and kill_wb_o are all 1. At the following edge, decode, execute and commit all become bubbles whose flags are clear, so no redirect follows in the next three cycles unless an interrupt is taken.
- R6: handler_pc_o equals the HANDLER_PC parameter whenever redirect_o is 1.
- R7: A rising edge of irq_req_i passes two synchronizing flops and is then latched as pending. The pending request is cleared only when it is taken. A request that is held high is taken exactly once.
- R8: Faults strobed for empty (invalid) slots are ignored. A pending interrupt waits until a valid instruction reaches commit.
- R9: The cause codes are 1 for a fetch address fault, 2 for an illegal opcode in decode, 3 for an overflow in execute and 4 for a data-address fault in the memory stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| fetch_valid_i | input | 1 | Fetch stage holds an instruction that enters decode at the next edge |
| fetch_pc_i | input | PC_W | PC of the fetched instruction |
| fetch_addr_fault_i | input | 1 | Fetch address fault for the fetched instruction |
| dec_illegal_i | input | 1 | Illegal opcode for the instruction now in decode |
| exe_overflow_i | input | 1 | Arithmetic overflow for the instruction now in execute |
| mem_addr_fault_i | input | 1 | Data-address fault for the instruction now at commit |
| irq_req_i | input | 1 | Asynchronous external interrupt request |
| kill_fetch_o | output | 1 | Discard the instruction in fetch |
| kill_dec_o | output | 1 | Discard the instruction in decode |
| kill_exe_o | output | 1 | Discard the instruction in execute |
| kill_wb_o | output | 1 | Block writeback of the instruction at commit |
| redirect_o | output | 1 | Steer the next fetch to handler_pc_o |
| handler_pc_o | output | PC_W | Handler entry address |
| cause_o | output | 3 | Cause register |
| epc_o | output | PC_W | Exception-PC register |

## Verification
The main function is tried with several kinds of stream. A single faulting instruction shows the three-cycle carry delay and that each source maps to its own cause code. Two faults on the same instruction separate first-stage-wins from last-stage-wins. An older overflow followed by a younger fetch fault shows whether killed instructions are really cleared. Interrupt patterns cover three cases: an interrupt arriving together with a data-address fault, which shows the override; a request held high, which tells level from edge capture; and a pulse into an empty pipeline, which shows the request is held pending. Idle slots driven with every fault strobe high tell gated flags from ungated ones.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CAUSE_W = 3;
  localparam int N_CARRY = 3;  // decode, execute, memory slots

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_IADDR   = 3'd1,
    CAUSE_ILLEGAL = 3'd2,
    CAUSE_OVF     = 3'd3,
    CAUSE_DADDR   = 3'd4,
    CAUSE_IRQ     = 3'd5
  } cause_e;

  typedef struct packed {
    logic   vld;
    logic   exc;
    cause_e cause;
  } slot_tag_t;

  localparam slot_tag_t TAG_BUBBLE = '{vld: 1'b0, exc: 1'b0, cause: CAUSE_NONE};

  // fault raised while an instruction moves from slot k-1 into slot k
  function automatic cause_e stage_cause(int unsigned k);
    case (k)
      0:       return CAUSE_IADDR;
      1:       return CAUSE_ILLEGAL;
      default: return CAUSE_OVF;
    endcase
  endfunction
endpackage

// File: rtl/exc_stage.sv
module exc_stage
  import exc_pkg::*;
#(
  parameter int     PC_W  = 32,
  parameter cause_e RAISE = CAUSE_IADDR
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            kill_i,
  input  slot_tag_t       in_tag_i,
  input  logic [PC_W-1:0] in_pc_i,
  input  logic            fault_i,
  output slot_tag_t       out_tag_o,
  output logic [PC_W-1:0] out_pc_o
);
  slot_tag_t       tag_d, tag_q;
  logic [PC_W-1:0] pc_q;
  logic            pc_en;

  always_comb begin
    tag_d     = in_tag_i;
    tag_d.exc = in_tag_i.vld & (in_tag_i.exc | fault_i);
    if (!in_tag_i.vld)     tag_d.cause = CAUSE_NONE;
    else if (in_tag_i.exc) tag_d.cause = in_tag_i.cause;   // older cause kept
    else if (fault_i)      tag_d.cause = RAISE;
    else                   tag_d.cause = CAUSE_NONE;
    if (kill_i) tag_d = TAG_BUBBLE;
    pc_en = in_tag_i.vld & ~kill_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= TAG_BUBBLE;
      pc_q  <= '0;
    end else begin
      tag_q <= tag_d;
      if (pc_en) pc_q <= in_pc_i;
    end
  end

  assign out_tag_o = tag_q;
  assign out_pc_o  = pc_q;
endmodule

// File: rtl/exc_irq_sync.sv
module exc_irq_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic take_i,
  output logic pend_o
);
  localparam int CHAIN = SYNC_STAGES + 1;  // extra flop for edge detect

  logic [CHAIN-1:0] chain_q;
  logic             pend_q, pend_d, rise;

  always_comb begin
    rise   = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    pend_d = (pend_q & ~take_i) | rise;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[CHAIN-2:0], irq_i};
      pend_q  <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/exc_commit.sv
module exc_commit
  import exc_pkg::*;
#(
  parameter int            PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  slot_tag_t          m_tag_i,
  input  logic [PC_W-1:0]    m_pc_i,
  input  logic               daddr_fault_i,
  input  logic               irq_pend_i,
  output logic               take_o,
  output logic               take_irq_o,
  output logic [PC_W-1:0]    handler_pc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [PC_W-1:0]    epc_o
);
  cause_e          sync_cause, sel_cause, cause_q;
  logic [PC_W-1:0] epc_q;
  logic            take_sync, take;

  always_comb begin
    sync_cause = m_tag_i.exc ? m_tag_i.cause
               : (daddr_fault_i ? CAUSE_DADDR : CAUSE_NONE);
    take_irq_o = irq_pend_i & m_tag_i.vld;
    take_sync  = m_tag_i.vld & (m_tag_i.exc | daddr_fault_i);
    take       = take_irq_o | take_sync;
    sel_cause  = take_irq_o ? CAUSE_IRQ : sync_cause;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= CAUSE_NONE;
      epc_q   <= '0;
    end else if (take) begin
      cause_q <= sel_cause;
      epc_q   <= m_pc_i;
    end
  end

  assign take_o       = take;
  assign handler_pc_o = HANDLER_PC;
  assign cause_o      = cause_q;
  assign epc_o        = epc_q;
endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
  import exc_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0400
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fetch_valid_i,
  input  logic [PC_W-1:0]    fetch_pc_i,
  input  logic               fetch_addr_fault_i,
  input  logic               dec_illegal_i,
  input  logic               exe_overflow_i,
  input  logic               mem_addr_fault_i,
  input  logic               irq_req_i,
  output logic               kill_fetch_o,
  output logic               kill_dec_o,
  output logic               kill_exe_o,
  output logic               kill_wb_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    handler_pc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [PC_W-1:0]    epc_o
);
  slot_tag_t          st_tag [N_CARRY+1];
  logic [PC_W-1:0]    st_pc  [N_CARRY+1];
  logic [N_CARRY-1:0] st_fault;
  logic               take, take_irq, irq_pend;
  logic               m_vld;
  logic [PC_W-1:0]    m_pc;

  assign st_tag[0] = '{vld: fetch_valid_i, exc: 1'b0, cause: CAUSE_NONE};
  assign st_pc[0]  = fetch_pc_i;
  assign st_fault  = {exe_overflow_i, dec_illegal_i, fetch_addr_fault_i};

  for (genvar k = 0; k < N_CARRY; k++) begin : g_slot
    exc_stage #(.PC_W(PC_W), .RAISE(stage_cause(k))) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .kill_i    (take),
      .in_tag_i  (st_tag[k]),
      .in_pc_i   (st_pc[k]),
      .fault_i   (st_fault[k]),
      .out_tag_o (st_tag[k+1]),
      .out_pc_o  (st_pc[k+1])
    );
  end

  exc_irq_sync #(.SYNC_STAGES(2)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_req_i),
    .take_i (take_irq),
    .pend_o (irq_pend)
  );

  exc_commit #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_commit (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .m_tag_i       (st_tag[N_CARRY]),
    .m_pc_i        (st_pc[N_CARRY]),
    .daddr_fault_i (mem_addr_fault_i),
    .irq_pend_i    (irq_pend),
    .take_o        (take),
    .take_irq_o    (take_irq),
    .handler_pc_o  (handler_pc_o),
    .cause_o       (cause_o),
    .epc_o         (epc_o)
  );

  assign m_vld        = st_tag[N_CARRY].vld;
  assign m_pc         = st_pc[N_CARRY];
  assign kill_fetch_o = take;
  assign kill_dec_o   = take;
  assign kill_exe_o   = take;
  assign kill_wb_o    = take;
  assign redirect_o   = take;
endmodule

// File: rtl/exc_commit_chk.sv
module exc_commit_chk #(
  parameter int PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            redirect_o,
  input logic [2:0]      cause_o,
  input logic [PC_W-1:0] epc_o,
  input logic            m_vld,
  input logic [PC_W-1:0] m_pc,
  input logic            irq_pend
);
  AST_BUBBLE_AFTER_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o);  // R5
  AST_TAKE_NEEDS_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> m_vld);  // R8
  AST_EPC_FROM_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> (epc_o == $past(m_pc)));  // R4
  AST_REGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redirect_o |=> ($stable(cause_o) && $stable(epc_o)));  // R4
  AST_IRQ_OVERRIDES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_pend && m_vld) |=> (cause_o == 3'd5));  // R3
  AST_CAUSE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_o <= 3'd5);  // R9
endmodule

bind exc_commit_ctrl exc_commit_chk #(.PC_W(PC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .redirect_o (redirect_o),
  .cause_o    (cause_o),
  .epc_o      (epc_o),
  .m_vld      (m_vld),
  .m_pc       (m_pc),
  .irq_pend   (irq_pend)
);

// File: tb/tb_exc_commit_ctrl.sv
module tb_exc_commit_ctrl;
  localparam int          PC_W    = 32;
  localparam logic [31:0] HANDLER = 32'h0000_0400;

  logic clk, rst_n;
  logic fv, iaf, ill, ovf, daf, irq;
  logic [31:0] fpc;
  logic kf, kd, ke, kwb, redir;
  logic [31:0] hpc, epc;
  logic [2:0] cause;

  exc_commit_ctrl #(.PC_W(PC_W), .HANDLER_PC(HANDLER)) dut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_valid_i(fv), .fetch_pc_i(fpc),
    .fetch_addr_fault_i(iaf), .dec_illegal_i(ill), .exe_overflow_i(ovf),
    .mem_addr_fault_i(daf), .irq_req_i(irq), .kill_fetch_o(kf), .kill_dec_o(kd),
    .kill_exe_o(ke), .kill_wb_o(kwb), .redirect_o(redir), .handler_pc_o(hpc),
    .cause_o(cause), .epc_o(epc));

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int checks = 0, errors = 0;
  logic [31:0] pc_ctr;
  logic last_redir;
  logic [31:0] last_hpc;
  int redir_cnt;

  // behavioural reference: slot 0 decode, 1 execute, 2 commit
  typedef struct packed { logic v; logic [31:0] pc; logic [2:0] c; } ent_t;
  ent_t mdl [3];
  logic [2:0]  m_cause;
  logic [31:0] m_epc;
  logic s1, s2, s3, pend;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic ent_t carry(input ent_t e, input logic f, input logic [2:0] code);
    ent_t r = e;
    if (!e.v) r = '0;
    else if (e.c == 3'd0 && f) r.c = code;
    return r;
  endfunction

  task automatic step(input logic v, input logic a, input logic il,
                      input logic ov, input logic da, input logic rq);
    logic       e_take, e_irq;
    logic [2:0] e_c;
    ent_t       nd;
    fv = v; fpc = pc_ctr; iaf = a; ill = il; ovf = ov; daf = da; irq = rq;
    #1;
    e_irq  = pend && mdl[2].v;
    e_c    = e_irq ? 3'd5 : (mdl[2].c != 0 ? mdl[2].c : ((mdl[2].v && da) ? 3'd4 : 3'd0));
    e_take = mdl[2].v && (e_c != 0);
    chk("R5 kills", {kf, kd, ke, kwb}, {4{e_take}});
    chk("R6 redirect", redir, e_take);
    if (e_take) chk("R6 handler", hpc, HANDLER);
    chk("R4 cause/epc", {cause, epc}, {m_cause, m_epc});
    last_redir = redir; last_hpc = hpc;
    if (redir) redir_cnt++;
    @(posedge clk);
    if (e_take) begin
      m_cause = e_c; m_epc = mdl[2].pc;
      mdl[0] = '0; mdl[1] = '0; mdl[2] = '0;
    end else begin
      nd = '{v: v, pc: (v ? pc_ctr : 32'd0), c: ((v && a) ? 3'd1 : 3'd0)};
      mdl[2] = carry(mdl[1], ov, 3'd3);
      mdl[1] = carry(mdl[0], il, 3'd2);
      mdl[0] = nd;
    end
    pend = (pend && !e_irq) || (s2 && !s3);
    s3 = s2; s2 = s1; s1 = rq;
    if (v) pc_ctr += 32'd4;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog expired got 0 expected 1");
    finish_run();
  end

  initial begin
    logic [31:0] a_pc;
    rst_n = 1'b0; fv = 0; fpc = 0; iaf = 0; ill = 0; ovf = 0; daf = 0; irq = 0;
    pc_ctr = 32'h100; redir_cnt = 0;
    for (int i = 0; i < 3; i++) mdl[i] = '0;
    m_cause = 0; m_epc = 0; s1 = 0; s2 = 0; s3 = 0; pend = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    chk("R4 reset", {redir, cause, epc}, 36'd0);

    // clean stream
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, 0);
    idle(3);

    // R1 fetch fault, acted on only at commit
    a_pc = pc_ctr;
    step(1, 1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0); step(1, 0, 0, 0, 0, 0);
    chk("R1 no early redirect", last_redir, 1'b0);
    step(1, 0, 0, 0, 0, 0);
    chk("R1 redirect at commit", last_redir, 1'b1);
    chk("R6 handler pc", last_hpc, HANDLER);
    chk("R9 cause iaddr", cause, 3'd1);
    chk("R1 epc", epc, a_pc);
    // R8 bubbles with every strobe high stay quiet
    for (int i = 0; i < 4; i++) begin
      step(0, 1, 1, 1, 1, 0);
      chk("R8 idle strobes ignored", last_redir, 1'b0);
    end

    // R9 illegal opcode
    step(1, 0, 0, 0, 0, 0); step(1, 0, 1, 0, 0, 0); idle(2);
    chk("R9 cause illegal", cause, 3'd2);
    idle(3);
    // R2 fetch fault and illegal on same instruction
    step(1, 1, 0, 0, 0, 0); step(0, 0, 1, 0, 0, 0); idle(2);
    chk("R2 earliest stage wins", cause, 3'd1);
    idle(3);
    // R9 overflow, then data-address fault
    step(1, 0, 0, 0, 0, 0); idle(1); step(0, 0, 0, 1, 0, 0); idle(1);
    chk("R9 cause overflow", cause, 3'd3);
    idle(3);
    step(1, 0, 0, 0, 0, 0); idle(2); step(0, 0, 0, 0, 1, 0);
    chk("R9 cause daddr", cause, 3'd4);
    idle(3);

    // R5 older overflow commits, younger fetch fault is killed
    a_pc = pc_ctr;
    step(1, 0, 0, 0, 0, 0); step(1, 1, 0, 0, 0, 0); step(0, 0, 0, 1, 0, 0); idle(1);
    chk("R5 older taken", {cause, epc}, {3'd3, a_pc});
    redir_cnt = 0;
    idle(4);
    chk("R5 killed younger silent", redir_cnt, 0);
    chk("R5 cause kept", cause, 3'd3);

    // R3 interrupt against a data-address fault, held high for R7
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0);
    a_pc = pc_ctr;
    redir_cnt = 0;
    step(1, 0, 0, 0, 0, 1); step(1, 0, 0, 0, 0, 1); step(1, 0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 1, 1);
    chk("R3 irq taken", last_redir, 1'b1);
    chk("R3 irq cause", cause, 3'd5);
    chk("R3 irq epc", epc, a_pc);
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0, 1);
    chk("R7 held request taken once", redir_cnt, 1);
    irq = 0;
    idle(6);

    // R8/R7 pulse into empty pipeline stays pending
    redir_cnt = 0;
    step(0, 0, 0, 0, 0, 1); idle(6);
    chk("R8 irq waits for instruction", redir_cnt, 0);
    a_pc = pc_ctr;
    step(1, 0, 0, 0, 0, 0); idle(2); step(0, 0, 0, 0, 0, 0);
    chk("R7 pending irq taken", {last_redir, cause, epc}, {1'b1, 3'd5, a_pc});
    idle(4);
    finish_run();
  end
endmodule